// File: doc/BRIEF.md
# Multi-Endpoint Transmit Prefetch Buffer

This block is the transmit staging buffer of a USB device controller. A single two-port storage array is divided into equal, independent channels, one per IN endpoint. When software primes an endpoint, the memory-fetch engine streams the first words of the outgoing data into that endpoint's channel. Once a set number of leading words is present, the endpoint is reported as primed. From then on the packet serializer can answer a host IN token at once, without waiting on the system bus.

While the serializer drains a channel, the fetch engine keeps writing behind it. A per-channel room flag throttles the fetch engine, and a per-channel empty flag guides the serializer. A read that finds a streaming channel empty is reported as an underrun. Each stored word is 36 bits wide: data in bits [31:0] and one valid flag per byte in bits [35:32], so a trailing partial word can be marked.

Every channel runs its own small state machine. Its states are CH_IDLE (not armed), CH_FILL (prime seen, leading data loading), CH_READY (primed, no word sent yet) and CH_STREAM (packet in progress, refill continues). The transitions are:
- `prime`: CH_IDLE to CH_FILL.
- `lead_done`: CH_FILL to CH_READY, once the fill count reaches LEAD_WORDS.
- `first_read`: CH_READY to CH_STREAM.
- `pkt_end`: CH_READY or CH_STREAM to CH_IDLE, on a read with the last flag set.
- `flush`: any state to CH_IDLE.

Top module: `tx_prefetch_fifo`

## Requirements
- R1: After reset, every channel is empty with room, no endpoint is primed, and tx_word_valid is low.
- R2: After a one-cycle prime pulse, fetch words for that endpoint are stored. The primed bit rises on the clock edge after the one that brings the fill count to LEAD_WORDS (default 8), and not earlier.
- R3: A fetch word sent to an endpoint in CH_IDLE is dropped, and the channel stays empty.
- R4: Filling or priming one endpoint leaves the empty and primed flags of every other endpoint unchanged.
- R5: Words leave a channel in the order they were written, with all 36 bits intact (data in [31:0], byte-valid flags in [35:32]). tx_word carries the word, with tx_word_valid high, in the cycle after an accepted tx_rd.
- R6: A channel that holds DEPTH (default 128) words drops its room flag and ignores further fetch words.
- R7: A fetch write and a serializer read to the same channel in the same cycle both take effect.
- R8: A tx_rd to an empty channel in CH_STREAM raises underrun for that endpoint in that cycle, and no word is returned.
- R9: A read with tx_last set ends the packet, and the primed bit is low after that edge.
- R10: A flush pulse empties the channel and clears its primed bit in one cycle. It takes priority over a fetch write in the same cycle.
- R11: A tx_rd to a channel in CH_FILL is ignored, and its stored words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prime_req | input | NUM_EP | Per-endpoint prime pulse |
| flush_req | input | NUM_EP | Per-endpoint flush pulse |
| fetch_valid | input | 1 | Fetch word present |
| fetch_ep | input | EPW | Endpoint the fetch word belongs to |
| fetch_word | input | 36 | Byte-valid flags [35:32], data [31:0] |
| fetch_room | output | NUM_EP | Channel is not full |
| tx_rd | input | 1 | Serializer read request |
| tx_ep | input | EPW | Endpoint to read |
| tx_last | input | 1 | This read is the last word of the packet |
| tx_word | output | 36 | Word read, one cycle after the request |
| tx_word_valid | output | 1 | tx_word holds a word |
| chan_empty | output | NUM_EP | Channel holds no words |
| ep_primed | output | NUM_EP | Endpoint primed status |
| underrun | output | NUM_EP | Read of an empty streaming channel |

## Verification
A fetch write and a serializer read can land on the same channel in the same cycle. The bench forces this on a streaming channel: it drives a new fetch word together with tx_rd. It then checks that the returned word is the oldest one held and that the new word comes out after the remaining old words. A second collision, a flush together with a fetch write, is judged by reading a fresh fill after re-priming. The first word returned must be a new one, which shows the word written during the flush was dropped.

// File: rtl/txpf_pkg.sv
package txpf_pkg;
    typedef enum logic [1:0] {
        CH_IDLE,
        CH_FILL,
        CH_READY,
        CH_STREAM
    } chan_state_t;

    localparam int WORD_W = 36;
endpackage

// File: rtl/txpf_mem.sv
module txpf_mem #(
    parameter int ENTRIES = 768,
    parameter int W       = 36,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] store [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/txpf_chan.sv
module txpf_chan
    import txpf_pkg::*;
#(
    parameter int DEPTH      = 128,
    parameter int LEAD_WORDS = 8,
    localparam int PW        = $clog2(DEPTH),
    localparam int CW        = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prime_i,
    input  logic          flush_i,
    input  logic          wr_req_i,
    input  logic          rd_req_i,
    input  logic          rd_last_i,
    output logic          wr_ok_o,
    output logic          rd_ok_o,
    output logic [PW-1:0] wr_ptr_o,
    output logic [PW-1:0] rd_ptr_o,
    output logic          room_o,
    output logic          empty_o,
    output logic          primed_o,
    output logic          underrun_o
);
    chan_state_t   state_q, state_d;
    logic [CW-1:0] count_q;
    logic [PW-1:0] wptr_q, rptr_q;
    logic          full, empty;

    assign full  = (count_q == CW'(DEPTH));
    assign empty = (count_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:   if (prime_i) state_d = CH_FILL;
            CH_FILL:   if (count_q >= CW'(LEAD_WORDS)) state_d = CH_READY;
            CH_READY:  if (rd_ok_o) state_d = rd_last_i ? CH_IDLE : CH_STREAM;
            CH_STREAM: if (rd_ok_o && rd_last_i) state_d = CH_IDLE;
            default:   state_d = CH_IDLE;
        endcase
        if (flush_i) state_d = CH_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        wr_ok_o    = wr_req_i && !full && (state_q != CH_IDLE) && !flush_i;
        rd_ok_o    = rd_req_i && !empty && !flush_i &&
                     (state_q == CH_READY || state_q == CH_STREAM);
        underrun_o = rd_req_i && empty && !flush_i && (state_q == CH_STREAM);
        primed_o   = (state_q == CH_READY) || (state_q == CH_STREAM);
        room_o     = !full;
        empty_o    = empty;
        wr_ptr_o   = wptr_q;
        rd_ptr_o   = rptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            wptr_q  <= '0;
            rptr_q  <= '0;
        end else if (flush_i) begin
            count_q <= '0;
            wptr_q  <= '0;
            rptr_q  <= '0;
        end else begin
            if (wr_ok_o) wptr_q <= wptr_q + 1'b1;
            if (rd_ok_o) rptr_q <= rptr_q + 1'b1;
            count_q <= count_q + CW'(wr_ok_o) - CW'(rd_ok_o);
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req_i && !rd_ok_o && !flush_i) |=> (count_q == CW'(DEPTH)));

    assert_primed_after_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(primed_o) |-> (count_q >= CW'(LEAD_WORDS)));

    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (count_q == '0 && !primed_o));

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && !flush_i) |=> (count_q == $past(count_q)));
endmodule

// File: rtl/tx_prefetch_fifo.sv
module tx_prefetch_fifo
    import txpf_pkg::*;
#(
    parameter int NUM_EP     = 6,
    parameter int DEPTH      = 128,
    parameter int LEAD_WORDS = 8,
    localparam int EPW       = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
    localparam int PW        = $clog2(DEPTH),
    localparam int ENTRIES   = NUM_EP * DEPTH,
    localparam int AW        = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] prime_req,
    input  logic [NUM_EP-1:0] flush_req,
    input  logic              fetch_valid,
    input  logic [EPW-1:0]    fetch_ep,
    input  logic [WORD_W-1:0] fetch_word,
    output logic [NUM_EP-1:0] fetch_room,
    input  logic              tx_rd,
    input  logic [EPW-1:0]    tx_ep,
    input  logic              tx_last,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_word_valid,
    output logic [NUM_EP-1:0] chan_empty,
    output logic [NUM_EP-1:0] ep_primed,
    output logic [NUM_EP-1:0] underrun
);
    logic [NUM_EP-1:0] wr_ok, rd_ok;
    logic [PW-1:0]     wptr_a [NUM_EP];
    logic [PW-1:0]     rptr_a [NUM_EP];
    logic [PW-1:0]     sel_wptr, sel_rptr;
    logic [AW-1:0]     waddr, raddr;

    for (genvar i = 0; i < NUM_EP; i++) begin : g_chan
        txpf_chan #(
            .DEPTH      (DEPTH),
            .LEAD_WORDS (LEAD_WORDS)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .prime_i    (prime_req[i]),
            .flush_i    (flush_req[i]),
            .wr_req_i   (fetch_valid && (fetch_ep == EPW'(i))),
            .rd_req_i   (tx_rd && (tx_ep == EPW'(i))),
            .rd_last_i  (tx_last),
            .wr_ok_o    (wr_ok[i]),
            .rd_ok_o    (rd_ok[i]),
            .wr_ptr_o   (wptr_a[i]),
            .rd_ptr_o   (rptr_a[i]),
            .room_o     (fetch_room[i]),
            .empty_o    (chan_empty[i]),
            .primed_o   (ep_primed[i]),
            .underrun_o (underrun[i])
        );
    end

    always_comb begin
        sel_wptr = '0;
        sel_rptr = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (fetch_ep == EPW'(i)) sel_wptr = wptr_a[i];
            if (tx_ep == EPW'(i))    sel_rptr = rptr_a[i];
        end
        waddr = AW'(fetch_ep) * AW'(DEPTH) + AW'(sel_wptr);
        raddr = AW'(tx_ep) * AW'(DEPTH) + AW'(sel_rptr);
    end

    txpf_mem #(
        .ENTRIES (ENTRIES),
        .W       (WORD_W)
    ) u_mem (
        .clk   (clk),
        .we    (|wr_ok),
        .waddr (waddr),
        .wdata (fetch_word),
        .re    (|rd_ok),
        .raddr (raddr),
        .rdata (tx_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_word_valid <= 1'b0;
        else        tx_word_valid <= |rd_ok;
    end

    assert_underrun_no_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|underrun) |=> !tx_word_valid);

    assert_valid_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_word_valid |-> $past(tx_rd));

    assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_ok));
endmodule

// File: tb/tb_tx_prefetch_fifo.sv
`timescale 1ns/1ps
module tb_tx_prefetch_fifo;
    localparam int NUM_EP = 6;
    localparam int DEPTH  = 128;
    localparam int LEAD   = 8;
    localparam int EPW    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_EP-1:0] prime_req = '0, flush_req = '0;
    logic              fetch_valid = 1'b0;
    logic [EPW-1:0]    fetch_ep = '0;
    logic [35:0]       fetch_word = '0;
    logic [NUM_EP-1:0] fetch_room, chan_empty, ep_primed, underrun;
    logic              tx_rd = 1'b0, tx_last = 1'b0, tx_word_valid;
    logic [EPW-1:0]    tx_ep = '0;
    logic [35:0]       tx_word;

    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    tx_prefetch_fifo dut (.*);

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(int ep, logic [35:0] w);
        fetch_valid = 1'b1; fetch_ep = EPW'(ep); fetch_word = w;
        cyc();
        fetch_valid = 1'b0;
    endtask

    task automatic prime(int ep);
        prime_req[ep] = 1'b1;
        cyc();
        prime_req = '0;
    endtask

    task automatic pull(int ep, bit last, output logic [35:0] w, output logic v);
        tx_rd = 1'b1; tx_ep = EPW'(ep); tx_last = last;
        cyc();
        tx_rd = 1'b0; tx_last = 1'b0;
        w = tx_word; v = tx_word_valid;
    endtask

    function automatic logic [35:0] pat(int ep, int k);
        return {4'(k + 1), 8'(ep), 24'(k)};
    endfunction

    task automatic t_reset();
        chk("R1 primed", 64'(ep_primed), 64'h0);
        chk("R1 empty", 64'(chan_empty), 64'h3f);
        chk("R1 room", 64'(fetch_room), 64'h3f);
        chk("R1 valid", 64'(tx_word_valid), 64'h0);
    endtask

    task automatic t_idle_ignore();
        push(0, 36'h1_2345_6789);
        cyc();
        chk("R3 idle write dropped", 64'(chan_empty[0]), 64'h1);
    endtask

    task automatic t_prime();
        prime(1);
        for (int k = 0; k < LEAD; k++) push(1, pat(1, k));
        chk("R2 not primed at lead edge", 64'(ep_primed[1]), 64'h0);
        cyc();
        chk("R2 primed after lead", 64'(ep_primed[1]), 64'h1);
        chk("R4 only ep1 primed", 64'(ep_primed), 64'h02);
        chk("R4 others empty", 64'(chan_empty), 64'h3d);
    endtask

    task automatic t_read_in_fill();
        logic [35:0] w; logic v;
        prime(2);
        push(2, pat(2, 0));
        push(2, pat(2, 1));
        pull(2, 1'b0, w, v);
        chk("R11 read in fill ignored", 64'(v), 64'h0);
        chk("R11 data kept", 64'(chan_empty[2]), 64'h0);
    endtask

    task automatic t_order();
        logic [35:0] w; logic v;
        for (int k = 0; k < 4; k++) begin
            pull(1, 1'b0, w, v);
            chk("R5 valid", 64'(v), 64'h1);
            chk("R5 word order", 64'(w), 64'(pat(1, k)));
        end
        chk("R5 still primed while streaming", 64'(ep_primed[1]), 64'h1);
    endtask

    task automatic t_concurrent();
        logic [35:0] w; logic v;
        fetch_valid = 1'b1; fetch_ep = 3'd1; fetch_word = 36'hE_CAFE_0001;
        tx_rd = 1'b1; tx_ep = 3'd1;
        cyc();
        fetch_valid = 1'b0; tx_rd = 1'b0;
        chk("R7 read in collision", 64'(tx_word), 64'(pat(1, 4)));
        for (int k = 5; k < LEAD; k++) begin
            pull(1, 1'b0, w, v);
            chk("R7 old words first", 64'(w), 64'(pat(1, k)));
        end
        pull(1, 1'b0, w, v);
        chk("R7 new word stored", 64'(w), 64'h E_CAFE_0001);
        chk("R7 drained", 64'(chan_empty[1]), 64'h1);
    endtask

    task automatic t_underrun_end();
        logic [35:0] w; logic v;
        tx_rd = 1'b1; tx_ep = 3'd1; #1;
        chk("R8 underrun flag", 64'(underrun), 64'h02);
        cyc();
        tx_rd = 1'b0;
        chk("R8 no word", 64'(tx_word_valid), 64'h0);
        push(1, 36'h3_0000_00AB);
        pull(1, 1'b1, w, v);
        chk("R9 last word", 64'(w), 64'h3_0000_00AB);
        chk("R9 primed cleared", 64'(ep_primed[1]), 64'h0);
    endtask

    task automatic t_full();
        logic [35:0] w; logic v;
        int bad = 0;
        prime(3);
        for (int k = 0; k < DEPTH; k++) push(3, pat(3, k));
        chk("R6 room low", 64'(fetch_room[3]), 64'h0);
        push(3, 36'hF_DEAD_BEEF);
        for (int k = 0; k < DEPTH; k++) begin
            pull(3, 1'b0, w, v);
            if (w !== pat(3, k) || v !== 1'b1) bad++;
        end
        chk("R6 full contents", 64'(bad), 64'h0);
        chk("R6 extra dropped", 64'(chan_empty[3]), 64'h1);
    endtask

    task automatic t_flush();
        logic [35:0] w; logic v;
        prime(4);
        for (int k = 0; k < LEAD; k++) push(4, pat(4, k));
        cyc();
        flush_req[4] = 1'b1;
        fetch_valid = 1'b1; fetch_ep = 3'd4; fetch_word = 36'h5_5555_5555;
        cyc();
        flush_req = '0; fetch_valid = 1'b0;
        chk("R10 empty", 64'(chan_empty[4]), 64'h1);
        chk("R10 primed low", 64'(ep_primed[4]), 64'h0);
        prime(4);
        for (int k = 0; k < LEAD; k++) push(4, pat(4, k + 40));
        cyc();
        pull(4, 1'b0, w, v);
        chk("R10 fresh first word", 64'(w), 64'(pat(4, 40)));
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_idle_ignore();
        t_prime();
        t_read_in_fill();
        t_order();
        t_concurrent();
        t_underrun_end();
        t_full();
        t_flush();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule